// File: doc/BRIEF.md
# Resizer Vertical Phase Sequencer

This block steps an image resizer down the picture one output line at a time. It holds a position in input-line units with eight fraction bits. Each output line adds a programmed step to that position, so the vertical scale factor is 256 divided by the step. The integer carry of each addition says how many fresh input lines must be taken before the next output line. Zero means the same input pair is used again. The fraction goes out with each output line as the interpolation weight. The block does not do the interpolation arithmetic and does not hold the line buffers.

A run begins on a frame-start pulse and ends in one of two ways, chosen by a mode pin:
- **Output-limited:** a fixed number of output lines has been produced.
- **Input-limited:** a fixed number of input lines has been taken.

In input-limited mode the block records how many output lines it made, and it keeps the leftover position for the next run. A continuous option starts the next run from that leftover position instead of the programmed initial phase. A line interrupt fires after every programmed number of output lines.

Input lines arrive on a valid/ready pair (`lin_valid`/`lin_ready`). Output lines leave on a valid/ready pair (`out_valid`/`out_ready`). Each side may stall for any number of cycles:
- The block raises `lin_ready` only while it needs another input line.
- The block holds `out_valid` and `out_frac` steady until `out_ready` is seen.
- A line is consumed, or an output line is delivered, only in a cycle where both valid and ready are high.

Top module: `rsz_vstep`

## Requirements
- R1: After reset, `out_valid`, `lin_ready`, `irq` and `done` are 0, and `lines_made` and `last_phase` read 0.
- R2: After `frame_start`, the block takes `cfg_init_phase[13:8]`+1 input lines before offering the first output line. That first line carries `out_frac` = `cfg_init_phase[7:0]`.
- R3: After each delivered output line, the 15-bit sum of the current fraction and `cfg_step` gives the next state. Bits [7:0] are the next `out_frac`. Bits [14:8] are the number of input lines taken before the next output line is offered.
- R4: `lin_ready` and `out_valid` are never high together. Once `out_valid` is high it stays high, with `out_frac` unchanged, until `out_ready` is seen.
- R5: In output-limited mode (`cfg_in_limited`=0), the run ends after (`cfg_out_lines` with bit 0 forced to 1)+1 delivered lines. The count is therefore always even, and `lines_made` reports it.
- R6: In input-limited mode (`cfg_in_limited`=1), at most `cfg_in_lines`+1 input lines are taken. The run ends when that many have been taken and the next output line would need one more. `lines_made` then reports the number of output lines delivered.
- R7: `done` is high for exactly one cycle, the cycle after the ending event. From then until the next `frame_start`, `out_valid` and `lin_ready` stay 0.
- R8: At an input-limited end, `last_phase` takes the leftover position: the pending position minus 256 times the number of input lines taken. An output-limited run leaves `last_phase` unchanged.
- R9: With `cfg_continuous`=1 and `cfg_in_limited`=1, `frame_start` loads the position from `last_phase` instead of `cfg_init_phase`. The interrupt line count is also kept across the frame start.
- R10: `irq` pulses for one cycle, one cycle after every (`cfg_irq_every`+1)-th delivered output line.
- R11: When continuous operation is not selected, `frame_start` loads `cfg_init_phase`, clears the line counters and restarts the interrupt line count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle pulse that starts a run |
| cfg_step | input | 14 | Position step per output line, 8 fraction bits |
| cfg_init_phase | input | 14 | Starting position, 8 fraction bits |
| cfg_in_limited | input | 1 | 1 = input-limited ending, 0 = output-limited |
| cfg_continuous | input | 1 | 1 = carry the leftover position into the next run |
| cfg_out_lines | input | 12 | Output line limit minus one (bit 0 forced to 1) |
| cfg_in_lines | input | 12 | Input line limit minus one |
| cfg_irq_every | input | 13 | Interrupt interval minus one, in output lines |
| lin_valid | input | 1 | An input line is available |
| lin_ready | output | 1 | The block takes the available input line |
| out_valid | output | 1 | An output line may be produced |
| out_ready | input | 1 | Downstream accepts the output line |
| out_frac | output | 8 | Interpolation fraction for the offered output line |
| irq | output | 1 | Periodic line interrupt pulse |
| done | output | 1 | One-cycle end-of-run pulse |
| lines_made | output | 13 | Output lines delivered in the last finished run |
| last_phase | output | 14 | Leftover position from the last input-limited run |

## Verification
`lin_ready`, `out_valid` and `out_frac` come straight from registers. They are valid in the cycle after the edge that changed them, so the monitor samples them and both handshakes on the falling edge of the clock. `irq` appears one cycle after the output handshake that completes an interval. The monitor computes that expectation at one falling edge and compares it at the next. `done`, `lines_made` and `last_phase` are all updated by the same edge that follows the ending event. The driver reads all three at the first falling edge where `done` is seen, then checks the idle outputs one cycle later.

// File: rtl/rsz_vstep_pkg.sv
package rsz_vstep_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } vstep_state_e;
endpackage

// File: rtl/vstep_accum.sv
module vstep_accum #(
  parameter int PH_W   = 14,
  parameter int FRAC_W = 8,
  localparam int SKIP_W = PH_W - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PH_W-1:0]   load_val,
  input  logic              take_line,
  input  logic              advance,
  input  logic [PH_W-1:0]   step,
  output logic [FRAC_W-1:0] frac,
  output logic [SKIP_W-1:0] skip
);
  logic [PH_W:0] sum;

  assign sum = {{SKIP_W{1'b0}}, frac} + {1'b0, step};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac <= '0;
      skip <= '0;
    end else if (load) begin
      frac <= load_val[FRAC_W-1:0];
      skip <= {1'b0, load_val[PH_W-1:FRAC_W]} + SKIP_W'(1);
    end else if (advance) begin
      frac <= sum[FRAC_W-1:0];
      skip <= sum[PH_W:FRAC_W];
    end else if (take_line) begin
      skip <= skip - SKIP_W'(1);
    end
  end
endmodule

// File: rtl/vstep_count.sv
module vstep_count #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/vstep_irq.sv
module vstep_irq #(
  parameter int IRQ_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             fire,
  input  logic [IRQ_W-1:0] every,
  output logic             irq
);
  logic [IRQ_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (clr) begin
      cnt <= '0;
      irq <= 1'b0;
    end else if (fire) begin
      if (cnt == every) begin
        cnt <= '0;
        irq <= 1'b1;
      end else begin
        cnt <= cnt + IRQ_W'(1);
        irq <= 1'b0;
      end
    end else begin
      irq <= 1'b0;
    end
  end
endmodule

// File: rtl/rsz_vstep.sv
module rsz_vstep
  import rsz_vstep_pkg::*;
#(
  parameter int PH_W   = 14,
  parameter int FRAC_W = 8,
  parameter int CNT_W  = 12,
  parameter int IRQ_W  = 13,
  localparam int STAT_W = CNT_W + 1,
  localparam int SKIP_W = PH_W - FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [PH_W-1:0]   cfg_step,
  input  logic [PH_W-1:0]   cfg_init_phase,
  input  logic              cfg_in_limited,
  input  logic              cfg_continuous,
  input  logic [CNT_W-1:0]  cfg_out_lines,
  input  logic [CNT_W-1:0]  cfg_in_lines,
  input  logic [IRQ_W-1:0]  cfg_irq_every,
  input  logic              lin_valid,
  output logic              lin_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FRAC_W-1:0] out_frac,
  output logic              irq,
  output logic              done,
  output logic [STAT_W-1:0] lines_made,
  output logic [PH_W-1:0]   last_phase
);
  vstep_state_e      state;
  logic [FRAC_W-1:0] frac;
  logic [SKIP_W-1:0] skip;
  logic [STAT_W-1:0] in_cnt, out_cnt;
  logic [STAT_W-1:0] in_limit, out_limit;
  logic [CNT_W-1:0]  out_lines_odd;
  logic [PH_W-1:0]   resid;
  logic [PH_W:0]     pos_full;
  logic run, need_line, in_fire, out_fire;
  logic carry_mode, term_in, term_out;

  assign run           = (state == ST_RUN);
  assign need_line     = (skip != '0);
  assign carry_mode    = cfg_continuous & cfg_in_limited;
  assign out_lines_odd = cfg_out_lines | CNT_W'(1);
  assign in_limit      = STAT_W'(cfg_in_lines) + STAT_W'(1);
  assign out_limit     = STAT_W'(out_lines_odd) + STAT_W'(1);

  assign term_in   = run & cfg_in_limited & need_line & (in_cnt == in_limit);
  assign lin_ready = run & need_line & ~term_in;
  assign out_valid = run & ~need_line;
  assign out_frac  = frac;
  assign in_fire   = lin_valid & lin_ready;
  assign out_fire  = out_valid & out_ready;
  assign term_out  = ~cfg_in_limited & out_fire & ((out_cnt + STAT_W'(1)) == out_limit);

  assign pos_full   = {skip, frac};
  assign last_phase = resid;

  vstep_accum #(.PH_W(PH_W), .FRAC_W(FRAC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (frame_start),
    .load_val (carry_mode ? resid : cfg_init_phase),
    .take_line(in_fire),
    .advance  (out_fire),
    .step     (cfg_step),
    .frac     (frac),
    .skip     (skip)
  );

  vstep_count #(.W(STAT_W)) u_in_cnt (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(in_fire), .cnt(in_cnt)
  );

  vstep_count #(.W(STAT_W)) u_out_cnt (
    .clk(clk), .rst_n(rst_n), .clr(frame_start), .inc(out_fire), .cnt(out_cnt)
  );

  vstep_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (frame_start & ~carry_mode),
    .fire (out_fire),
    .every(cfg_irq_every),
    .irq  (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      done       <= 1'b0;
      lines_made <= '0;
      resid      <= '0;
    end else begin
      done <= (term_in | term_out) & ~frame_start;
      if (frame_start) begin
        state <= ST_RUN;
      end else if (term_in | term_out) begin
        state <= ST_IDLE;
      end
      if (term_out) begin
        lines_made <= out_cnt + STAT_W'(1);
      end
      if (term_in) begin
        lines_made <= out_cnt;
        resid      <= PH_W'(pos_full - (PH_W+1)'(1 << FRAC_W));
      end
    end
  end
endmodule

// File: rtl/rsz_vstep_chk.sv
module rsz_vstep_chk #(
  parameter int FRAC_W = 8,
  parameter int STAT_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              cfg_in_limited,
  input logic              lin_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FRAC_W-1:0] out_frac,
  input logic              irq,
  input logic              done,
  input logic [STAT_W-1:0] lines_made
);
  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && lin_ready));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=> (out_valid && $stable(out_frac)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!out_valid && !lin_ready));

  p_irq_after_fire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(out_valid && out_ready));

  p_even_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_in_limited) |-> !lines_made[0]);
endmodule

bind rsz_vstep rsz_vstep_chk #(.FRAC_W(FRAC_W), .STAT_W(STAT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start   (frame_start),
  .cfg_in_limited(cfg_in_limited),
  .lin_ready     (lin_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_frac      (out_frac),
  .irq           (irq),
  .done          (done),
  .lines_made    (lines_made)
);

// File: tb/sim_rsz_vstep.sv
`timescale 1ns/1ps
module sim_rsz_vstep;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [13:0] cfg_step = '0, cfg_init_phase = '0;
  logic cfg_in_limited = 1'b0, cfg_continuous = 1'b0;
  logic [11:0] cfg_out_lines = '0, cfg_in_lines = '0;
  logic [12:0] cfg_irq_every = 13'd2;
  logic lin_valid = 1'b0, out_ready = 1'b0;
  logic lin_ready, out_valid, irq, done;
  logic [7:0] out_frac;
  logic [12:0] lines_made;
  logic [13:0] last_phase;

  int n_checks = 0, n_errors = 0;
  int q_frac[$], q_need[$];
  int consumed = 0, irq_m = 0;
  bit irq_pend = 1'b0;
  int model_resid = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  rsz_vstep u0 (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stall patterns on both streams
  always @(posedge clk) begin
    #1;
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    lin_valid <= lfsr[3] | lfsr[7];
    out_ready <= lfsr[1] | lfsr[9];
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == irq_pend, "R10 irq timing", irq, irq_pend);
      irq_pend = 1'b0;
      if (lin_valid && lin_ready) consumed++;
      if (out_valid && out_ready) begin
        if (q_frac.size() == 0) begin
          chk(1'b0, "R5/R6 extra output line", 1, 0);
        end else begin
          int ef, en;
          ef = q_frac.pop_front();
          en = q_need.pop_front();
          chk(out_frac == ef, "R2/R3 out_frac", out_frac, ef);
          chk(consumed == en, "R2/R3 lines taken before output", consumed, en);
        end
        if (irq_m == int'(cfg_irq_every)) begin
          irq_m = 0;
          irq_pend = 1'b1;
        end else irq_m++;
      end
    end
  end

  task automatic run_frame(int init, int step, bit inlim, bit cont, int oval, int ival);
    int pos, total, made, lim, waited;
    @(posedge clk); #1;
    cfg_step = 14'(step); cfg_init_phase = 14'(init);
    cfg_in_limited = inlim; cfg_continuous = cont;
    cfg_out_lines = 12'(oval); cfg_in_lines = 12'(ival);
    pos = (cont && inlim) ? model_resid : init;
    made = 0; total = 0;
    q_frac.delete(); q_need.delete();
    if (!inlim) begin
      lim = (oval | 1) + 1;
      for (int k = 0; k < lim; k++) begin
        q_frac.push_back(pos % 256);
        q_need.push_back(pos / 256 + 1);
        total = pos / 256 + 1;
        pos += step;
      end
      made = lim;
    end else begin
      lim = ival + 1;
      while (pos / 256 + 1 <= lim) begin
        q_frac.push_back(pos % 256);
        q_need.push_back(pos / 256 + 1);
        made++;
        pos += step;
      end
      total = lim;
      model_resid = pos - 256 * lim;
    end
    consumed = 0;
    if (!(cont && inlim)) irq_m = 0;  // R11 interrupt count restart
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
    waited = 0;
    while (waited < 5000) begin
      @(negedge clk);
      if (done) break;
      waited++;
    end
    chk(waited < 5000, "R7 done seen", waited, 0);
    chk(lines_made == 13'(made), inlim ? "R6 lines_made" : "R5 lines_made", lines_made, made);
    chk(q_frac.size() == 0, "R5/R6 all lines delivered", q_frac.size(), 0);
    chk(consumed == total, inlim ? "R6 input lines taken" : "R3 input lines taken", consumed, total);
    chk(last_phase == 14'(model_resid), "R8 last_phase", last_phase, model_resid);
    @(negedge clk);
    chk(!done && !out_valid && !lin_ready, "R7 idle after done",
        {done, out_valid, lin_ready}, 0);
    repeat (3) @(negedge clk);
    chk(!out_valid && !lin_ready, "R7 stays idle", {out_valid, lin_ready}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !lin_ready && !irq && !done, "R1 reset outputs",
        {out_valid, lin_ready, irq, done}, 0);
    chk(lines_made == 0 && last_phase == 0, "R1 reset status", lines_made, 0);
    run_frame(14'h000, 14'h100, 0, 0, 5, 0);   // 1:1, R5
    run_frame(14'h0C0, 14'h080, 0, 0, 6, 0);   // upscale, R5 forced odd
    run_frame(14'h340, 14'h2A0, 0, 0, 2, 0);   // downscale, R2 skip
    run_frame(14'h040, 14'h180, 1, 0, 9, 9);   // R6 R8
    run_frame(14'h3FF, 14'h180, 1, 1, 0, 7);   // R9 continuous, init ignored
    run_frame(14'h000, 14'h100, 0, 0, 1, 0);   // R11 back to normal
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule